// File: doc/BRIEF.md
# Sliced VBI Ancillary Packet Parser

This block watches an 8-bit byte stream taken from one video line at a time. It looks for ancillary packets that carry sliced data from the vertical blanking interval. Each line opens with a four-byte timing code. On lines that qualify, the parser skips the idle bytes until it finds a packet preamble. It then reads the packet header: a field-coding identifier, a service selector, a word count and two internal-identifier bytes.

The payload bytes go out one per accepted input byte, each marked by a valid strobe. When the checksum byte arrives, the parser publishes the service type, the line number and the field for that packet. If the packet is malformed, it raises an error flag and drives those three results to zero instead. The results stay on the outputs until the next packet completes. The parser then skips the fill region that pads the packet, and searches for the next timing code.

A downstream capture engine uses the results to tag each payload with its service and its line. A per-channel line offset lets software line up the reported line numbers with the numbering it uses.

Top module: `vbi_anc_parser`

## Requirements
- R1: A timing code is the byte run 0xFF 0x00 0x00 followed by a status byte. With the default parameter BLANK_ONLY=1, only a status byte with bit 5 set (blanking, e.g. 0xB0 or 0xF0) starts a packet search. With bit 5 clear (e.g. 0x90 or 0xD0), the whole line is ignored: no done pulse and no payload.
- R2: After a qualifying timing code, all bytes are skipped until the three-byte preamble 0x00 0xFF 0xFF. The byte that follows the preamble is taken as the data identifier.
- R3: Identifier 0x91 gives rpt_second=0 and identifier 0x55 gives rpt_second=1. Any other value ends the packet at once: one done pulse with rpt_err=1 and zero type, line and field, no payload, and a return to the timing-code search.
- R4: Bits [3:0] of the byte after the identifier select the service, reported on rpt_type: 1 gives 1 (teletext), 4 gives 2 (wide-screen signalling), 6 gives 3 (closed caption) and 9 gives 4 (VPS). Bits [7:4] are ignored. Any other low-nibble value is an error.
- R5: rpt_line equals bits [5:0] of the first internal-identifier byte plus line_offset, modulo 2^LINE_W. The second internal-identifier byte is ignored.
- R6: The word-count byte sets NN, its low NN_W bits. Once the identifier is accepted, the NN data bytes after the internal identifier appear in order on pay_byte with pay_valid high. Each appears one clock after the clock edge that accepts it. This holds even if the service turns out to be in error.
- R7: For closed caption (rpt_type 3), the first two payload bytes must each have odd parity, meaning an odd number of ones. If either has even parity, or if NN is below 2, the packet is reported as an error.
- R8: The byte after the NN data bytes is the checksum. One clock after it is accepted, done pulses high for exactly one cycle. At the same time the results update. On an error, rpt_err=1 and rpt_type, rpt_line and rpt_second are all 0.
- R9: rpt_type, rpt_line, rpt_second and rpt_err hold their values between done pulses. All outputs are zero after reset.
- R10: The payload region counts from the first data byte and spans 4×NN bytes (1 byte when NN is 0). Bytes after the checksum inside that region are ignored. After the region, bytes are ignored until the next timing code, including any that look like a preamble.
- R11: The sequence 0xFF 0x00 0x00 seen in any state abandons the packet without a done pulse, and the next byte is taken as a status byte. The first two bytes of that sequence are still handled by the current state, so in a payload they are streamed out.
- R12: A byte is consumed only in a cycle with in_valid high. Idle cycles between bytes change no parse result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| line_offset | input | LINE_W | Added to the extracted line number |
| pay_valid | output | 1 | pay_byte holds a payload byte |
| pay_byte | output | 8 | Payload byte |
| done | output | 1 | One-cycle pulse when the results update |
| rpt_type | output | 3 | Service type: 0 none, 1 teletext, 2 WSS, 3 caption, 4 VPS |
| rpt_line | output | LINE_W | Reported line number |
| rpt_second | output | 1 | Packet belongs to the second field |
| rpt_err | output | 1 | Packet was malformed; results forced to zero |

## Verification
A parser that loses its place in a line gives itself away within a single line. A missed or spurious done pulse, or a payload byte count different from NN, shows one clock after the checksum should have arrived. A wrong header capture shows on rpt_type, rpt_line or rpt_second at that same done pulse. Because the results hold between pulses, a stray update is also caught on lines that must be ignored, where the outputs have to match the previous packet's values.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

   typedef enum logic [3:0] {
      PS_SEEK,   // waiting for a timing code
      PS_STAT,   // next byte is the timing status byte
      PS_HUNT,   // skipping idle bytes, looking for the preamble
      PS_IDENT,  // data identifier
      PS_SVC,    // service selector
      PS_COUNT,  // word count
      PS_TAG0,   // internal identifier, line-carrying byte
      PS_TAG1,   // internal identifier, ignored byte
      PS_BODY    // data, checksum and fill
   } pstate_t;

   typedef enum logic [2:0] {
      SVC_NONE = 3'd0,
      SVC_TTX  = 3'd1,
      SVC_WSS  = 3'd2,
      SVC_CC   = 3'd3,
      SVC_VPS  = 3'd4
   } svc_t;

   localparam logic [7:0] ID_FIELD1 = 8'h91;
   localparam logic [7:0] ID_FIELD2 = 8'h55;
   localparam int         TAG_LINE_W = 6;

   function automatic logic has_odd_ones(input logic [7:0] b);
      return ^b;
   endfunction

endpackage

// File: rtl/vbi_byte_hist.sv
module vbi_byte_hist (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       code_hit,
   output logic       pre_hit
);
   logic [7:0] prev1;   // most recent accepted byte
   logic [7:0] prev2;   // the one before it

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev1 <= 8'h00;
         prev2 <= 8'h00;
      end else if (in_valid) begin
         prev1 <= in_byte;
         prev2 <= prev1;
      end
   end

   assign code_hit = in_valid && (prev2 == 8'hFF) && (prev1 == 8'h00) && (in_byte == 8'h00);
   assign pre_hit  = in_valid && (prev2 == 8'h00) && (prev1 == 8'hFF) && (in_byte == 8'hFF);

endmodule

// File: rtl/vbi_svc_map.sv
module vbi_svc_map
   import vbi_anc_pkg::*;
(
   input  logic [3:0] sel,
   output svc_t       svc,
   output logic       known,
   output logic       is_cc
);
   always_comb begin
      known = 1'b1;
      unique case (sel)
         4'd1:    svc = SVC_TTX;
         4'd4:    svc = SVC_WSS;
         4'd6:    svc = SVC_CC;
         4'd9:    svc = SVC_VPS;
         default: begin
            svc   = SVC_NONE;
            known = 1'b0;
         end
      endcase
      is_cc = (svc == SVC_CC);
   end
endmodule

// File: rtl/vbi_anc_parser.sv
module vbi_anc_parser
   import vbi_anc_pkg::*;
#(
   parameter int LINE_W     = 10,
   parameter int NN_W       = 6,
   parameter bit BLANK_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic [LINE_W-1:0] line_offset,
   output logic              pay_valid,
   output logic [7:0]        pay_byte,
   output logic              done,
   output logic [2:0]        rpt_type,
   output logic [LINE_W-1:0] rpt_line,
   output logic              rpt_second,
   output logic              rpt_err
);
   localparam int CNT_W = NN_W + 2;   // holds 4*NN - 1

   if (LINE_W < TAG_LINE_W) begin : g_bad_line_w
      $error("LINE_W must be at least %0d", TAG_LINE_W);
   end
   if (NN_W < 1 || NN_W > 6) begin : g_bad_nn_w
      $error("NN_W must lie in 1..6");
   end

   logic code_hit, pre_hit;
   vbi_byte_hist u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .code_hit (code_hit),
      .pre_hit  (pre_hit)
   );

   svc_t map_svc;
   logic map_known, map_cc;
   vbi_svc_map u_map (
      .sel   (in_byte[3:0]),
      .svc   (map_svc),
      .known (map_known),
      .is_cc (map_cc)
   );

   logic stat_ok;
   if (BLANK_ONLY) begin : g_blank_only
      assign stat_ok = in_byte[5];
   end else begin : g_any_line
      assign stat_ok = 1'b1;
   end

   pstate_t                 st;
   logic                    second_r, err_r, cc_r;
   svc_t                    svc_r;
   logic [TAG_LINE_W-1:0]   tag_r;
   logic [NN_W-1:0]         nn_r;
   logic [CNT_W-1:0]        cnt_r;

   logic [CNT_W-1:0] nn_ext, last_idx;
   logic             in_data, at_ck, at_last, fin_err;
   assign nn_ext   = CNT_W'(nn_r);
   assign last_idx = (nn_r == '0) ? '0 : CNT_W'((nn_ext << 2) - 1'b1);
   assign in_data  = cnt_r < nn_ext;
   assign at_ck    = cnt_r == nn_ext;
   assign at_last  = cnt_r == last_idx;
   assign fin_err  = err_r || (cc_r && (nn_r < NN_W'(2)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= PS_SEEK;
         second_r   <= 1'b0;
         err_r      <= 1'b0;
         cc_r       <= 1'b0;
         svc_r      <= SVC_NONE;
         tag_r      <= '0;
         nn_r       <= '0;
         cnt_r      <= '0;
         pay_valid  <= 1'b0;
         pay_byte   <= 8'h00;
         done       <= 1'b0;
         rpt_type   <= 3'd0;
         rpt_line   <= '0;
         rpt_second <= 1'b0;
         rpt_err    <= 1'b0;
      end else begin
         done      <= 1'b0;
         pay_valid <= 1'b0;
         if (in_valid) begin
            if (code_hit) begin
               st <= PS_STAT;
            end else begin
               unique case (st)
                  PS_SEEK: st <= PS_SEEK;
                  PS_STAT: st <= stat_ok ? PS_HUNT : PS_SEEK;
                  PS_HUNT: if (pre_hit) st <= PS_IDENT;
                  PS_IDENT: begin
                     if (in_byte == ID_FIELD1 || in_byte == ID_FIELD2) begin
                        second_r <= (in_byte == ID_FIELD2);
                        st       <= PS_SVC;
                     end else begin
                        done       <= 1'b1;
                        rpt_type   <= 3'd0;
                        rpt_line   <= '0;
                        rpt_second <= 1'b0;
                        rpt_err    <= 1'b1;
                        st         <= PS_SEEK;
                     end
                  end
                  PS_SVC: begin
                     svc_r <= map_svc;
                     cc_r  <= map_cc;
                     err_r <= !map_known;
                     st    <= PS_COUNT;
                  end
                  PS_COUNT: begin
                     nn_r <= in_byte[NN_W-1:0];
                     st   <= PS_TAG0;
                  end
                  PS_TAG0: begin
                     tag_r <= in_byte[TAG_LINE_W-1:0];
                     st    <= PS_TAG1;
                  end
                  PS_TAG1: begin
                     cnt_r <= '0;
                     st    <= PS_BODY;
                  end
                  PS_BODY: begin
                     cnt_r <= cnt_r + 1'b1;
                     if (in_data) begin
                        pay_valid <= 1'b1;
                        pay_byte  <= in_byte;
                        if (cc_r && cnt_r < CNT_W'(2) && !has_odd_ones(in_byte))
                           err_r <= 1'b1;
                     end
                     if (at_ck) begin
                        done       <= 1'b1;
                        rpt_err    <= fin_err;
                        rpt_type   <= fin_err ? 3'd0 : 3'(svc_r);
                        rpt_line   <= fin_err ? '0 : LINE_W'(tag_r) + line_offset;
                        rpt_second <= fin_err ? 1'b0 : second_r;
                     end
                     if (at_last) st <= PS_SEEK;
                  end
                  default: st <= PS_SEEK;
               endcase
            end
         end
      end
   end

   // ---------------- assertions ----------------
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R8
   AST_ERR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rpt_err) |-> (rpt_type == 3'd0 && rpt_line == '0 && !rpt_second));  // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(rpt_type) && $stable(rpt_line) && $stable(rpt_second) && $stable(rpt_err)));  // R9
   AST_BYTE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid || done) |-> $past(in_valid));  // R12
   AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_type <= 3'd4);  // R4
   AST_PAY_NOT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      !(pay_valid && done));  // R6

endmodule

// File: tb/vbi_anc_parser_bench.sv
`timescale 1ns/1ps
module vbi_anc_parser_bench;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = 8'h00;
   logic [LW-1:0] line_offset = '0;
   logic          pay_valid, done, rpt_second, rpt_err;
   logic [7:0]    pay_byte;
   logic [2:0]    rpt_type;
   logic [LW-1:0] rpt_line;

   always #2.5 clk = ~clk;

   vbi_anc_parser #(.LINE_W(LW), .NN_W(6), .BLANK_ONLY(1'b1)) u_vbi_anc_parser (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .line_offset(line_offset), .pay_valid(pay_valid), .pay_byte(pay_byte),
      .done(done), .rpt_type(rpt_type), .rpt_line(rpt_line),
      .rpt_second(rpt_second), .rpt_err(rpt_err));

   int total = 0;
   int bad = 0;
   int done_cnt = 0;
   logic [7:0] pay_q[$];

   // expected held results
   int e_type = 0, e_line = 0, e_sec = 0, e_err = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt++;
         if (pay_valid) pay_q.push_back(pay_byte);
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #1000000;
      chk(1'b0, "R8", "watchdog expired", 0, 1);
      finish_up();
   end

   function automatic int svc_of(input logic [3:0] s);
      case (s)
         4'd1: return 1;
         4'd4: return 2;
         4'd6: return 3;
         4'd9: return 4;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] rnd_byte();
      return 8'(($urandom % 254) + 1);   // never 0x00 or 0xFF
   endfunction

   function automatic logic [7:0] with_parity(input logic [7:0] b, input bit want_odd);
      if ((^b) != want_odd) return b ^ 8'h01;
      return b;
   endfunction

   task automatic put(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
      if ($urandom % 4 == 0) @(negedge clk);   // R12 idle gaps
   endtask

   // pay_mode: 0 random, 1 odd parity on first two, 2 second byte even parity
   task automatic run_line(input bit no_code, input logic [7:0] stat, input logic [7:0] ident,
                           input logic [7:0] sel, input int nn, input logic [7:0] tag0,
                           input logic [LW-1:0] ofs, input int pay_mode, input int idles,
                           input bit fake_fill, input string tag);
      logic [7:0] pl[16];
      int exp_done, exp_pay, t, er, region, d0;
      for (int i = 0; i < 16; i++) pl[i] = rnd_byte();
      if (pay_mode == 1) begin pl[0] = with_parity(pl[0], 1); pl[1] = with_parity(pl[1], 1); end
      if (pay_mode == 2) begin pl[0] = with_parity(pl[0], 1); pl[1] = with_parity(pl[1], 0); end
      line_offset = ofs;
      pay_q.delete();
      d0 = done_cnt;
      // expected values from the requirements
      exp_done = 0; exp_pay = 0;
      if (stat[5]) begin                                       // R1
         if (ident != 8'h91 && ident != 8'h55) begin           // R3
            exp_done = 1; e_type = 0; e_line = 0; e_sec = 0; e_err = 1;
         end else begin
            t  = svc_of(sel[3:0]);                             // R4
            er = (t == 0) || (t == 3 && (nn < 2 || !(^pl[0]) || !(^pl[1])));  // R7
            exp_done = 1; exp_pay = nn;
            e_err  = er;
            e_type = er ? 0 : t;
            e_line = er ? 0 : ((int'(tag0 & 8'h3F) + int'(ofs)) % (1 << LW));  // R5
            e_sec  = er ? 0 : (ident == 8'h55);
         end
      end
      if (!no_code) begin put(8'hFF); put(8'h00); put(8'h00); end
      put(stat);
      for (int i = 0; i < idles; i++) put(rnd_byte());        // R2
      put(8'h00); put(8'hFF); put(8'hFF);
      put(ident); put(sel); put(8'(nn)); put(tag0); put(8'h80);
      for (int i = 0; i < nn; i++) put(pl[i]);
      put(rnd_byte());                                         // checksum
      region = (nn == 0) ? 1 : 4 * nn;
      for (int i = nn + 1; i < region; i++) begin
         if (fake_fill && i - nn - 1 < 3) put((i - nn - 1 == 0) ? 8'h00 : 8'hFF);
         else put(rnd_byte());
      end
      if (fake_fill) begin                                     // R10 after region
         put(8'h00); put(8'hFF); put(8'hFF); put(8'h91); put(8'h01); put(8'h02);
         put(8'h05); put(8'h80); put(8'h33); put(8'h44); put(8'h11);
      end
      repeat (4) @(negedge clk);
      chk(done_cnt - d0 == exp_done, "R8", {tag, " done count"}, done_cnt - d0, exp_done);
      chk(pay_q.size() == exp_pay, "R6", {tag, " payload count"}, pay_q.size(), exp_pay);
      for (int i = 0; i < exp_pay && i < pay_q.size(); i++)
         chk(pay_q[i] == pl[i], "R6", {tag, " payload byte"}, pay_q[i], pl[i]);
      chk(rpt_type == e_type, "R4", {tag, " type"}, rpt_type, e_type);
      chk(rpt_line == e_line, "R5", {tag, " line"}, rpt_line, e_line);
      chk(rpt_second == e_sec, "R3", {tag, " field"}, rpt_second, e_sec);
      chk(rpt_err == e_err, "R7", {tag, " error"}, rpt_err, e_err);
   endtask

   initial begin
      int d0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(done == 0 && pay_valid == 0, "R9", "reset strobes", {done, pay_valid}, 0);
      chk(rpt_type == 0 && rpt_line == 0 && rpt_second == 0 && rpt_err == 0, "R9", "reset results",
          rpt_type, 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_line(0, 8'hB0, 8'h91, 8'h01, 5, 8'h0C, 10'd3, 0, 2, 0, "R3 R4 teletext field1");
      run_line(0, 8'hF0, 8'h55, 8'h04, 3, 8'h17, 10'd0, 0, 0, 0, "R3 R4 wss field2");
      run_line(0, 8'hB0, 8'h91, 8'h06, 2, 8'h15, 10'd7, 1, 1, 0, "R7 caption good");
      run_line(0, 8'hF0, 8'h55, 8'h06, 2, 8'h15, 10'd7, 2, 1, 0, "R7 caption bad parity");
      run_line(0, 8'hB0, 8'h91, 8'h06, 1, 8'h15, 10'd7, 1, 0, 0, "R7 caption short");
      run_line(0, 8'hB0, 8'h91, 8'h09, 0, 8'h10, 10'd2, 0, 3, 0, "R8 vps empty");
      run_line(0, 8'hB0, 8'h91, 8'h03, 4, 8'h10, 10'd2, 0, 0, 0, "R4 unknown service");
      run_line(0, 8'hF0, 8'h55, 8'hA1, 2, 8'h10, 10'd2, 0, 0, 0, "R4 high nibble ignored");
      run_line(0, 8'hB0, 8'h93, 8'h01, 4, 8'h10, 10'd2, 0, 0, 0, "R3 bad identifier");
      run_line(0, 8'h90, 8'h91, 8'h01, 4, 8'h11, 10'd2, 0, 0, 0, "R1 active line ignored");
      run_line(0, 8'hD0, 8'h55, 8'h04, 4, 8'h11, 10'd2, 0, 0, 0, "R1 active line field2");
      run_line(0, 8'hB0, 8'h91, 8'h01, 3, 8'h3F, 10'd1023, 0, 0, 0, "R5 offset wrap");
      run_line(0, 8'hB0, 8'h91, 8'h01, 3, 8'hC5, 10'd100, 0, 0, 1, "R10 fake preamble in fill");

      // R11: a timing code inside the payload abandons the packet
      d0 = done_cnt;
      pay_q.delete();
      put(8'hFF); put(8'h00); put(8'h00); put(8'hB0);
      put(8'h00); put(8'hFF); put(8'hFF);
      put(8'h91); put(8'h01); put(8'h0A); put(8'h12); put(8'h80);
      put(8'h21); put(8'h22);
      put(8'hFF); put(8'h00); put(8'h00);
      repeat (3) @(negedge clk);
      chk(done_cnt == d0, "R11", "no done on abort", done_cnt - d0, 0);
      chk(pay_q.size() == 4, "R11", "bytes before abort", pay_q.size(), 4);
      run_line(1, 8'hF0, 8'h55, 8'h09, 3, 8'h08, 10'd5, 0, 1, 0, "R11 packet after abort");

      for (int n = 0; n < 40; n++) begin
         logic [7:0] st, id, sl;
         int pm;
         case ($urandom % 4)
            0: st = 8'hB0;
            1: st = 8'hF0;
            2: st = 8'h90;
            default: st = 8'hD0;
         endcase
         id = ($urandom % 8 == 0) ? 8'h42 : (($urandom % 2) ? 8'h91 : 8'h55);
         case ($urandom % 5)
            0: sl = 8'h01;
            1: sl = 8'h04;
            2: sl = 8'h06;
            3: sl = 8'h09;
            default: sl = 8'(($urandom % 16) << 4) | 8'($urandom % 16);
         endcase
         if (sl == 8'hFF) sl = 8'hF1;
         pm = $urandom % 3;
         run_line(0, st, id, sl, int'($urandom % 13), rnd_byte(), 10'($urandom),
                  pm, int'($urandom % 4), 0, "R2 R12 random");
      end
      finish_up();
   end
endmodule